// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a fast clock, taken from the oscillator that a synthesizer loop controls, by a programmable ratio N = P·B + A. It drives the modulus-control line of a two-modulus prescaler, which here is modelled digitally. Each output period starts with the prescaler dividing by P+1. A swallow counter counts A prescaler outputs and then switches the prescaler to divide by P. A main counter counts B prescaler outputs in total, then ends the period and reloads both counters. The block emits a single-cycle comparison pulse once per N input cycles. That pulse goes to a phase comparator together with the divided reference.

Software supplies the swallow count, the main count and a prescaler-size select as plain levels. The block samples these levels only at a period boundary, so a write never shortens or stretches the period in progress. Values outside the legal range are clamped, and a sticky error flag records that this happened. A counter-reset input clears the counters and holds them cleared. A powerdown input freezes every counter where it stands, and the count resumes from that point when powerdown is released.

Top module: `pswallow_divider`

## Requirements
- R1: `div_pulse` is high for exactly one cycle per period, and consecutive rising pulses are N = P·B + A clock cycles apart.
- R2: `mod_ctl` (1 = divide by P+1) is high for exactly A·(P+1) cycles at the start of each period and low for the rest of it. When A = 0 it is never high.
- R3: With `p_sel` = 0, P equals parameter P_SMALL (default 64). With `p_sel` = 1, P equals P_LARGE (default 128).
- R4: New `a_val`, `b_val` and `p_sel` levels are taken in only at the clock edge that ends a period, or while the counters are cleared. A change in the middle of a period leaves that period's length unchanged and sets the length of the next one.
- R5: A `b_val` below 3 is used as 3. An `a_val` above A_MAX (default 127) or above the effective B is used as the smaller of the two. Loading such values sets `prog_err`.
- R6: `prog_err` stays high once set and is cleared only by `rst_n` low.
- R7: While `cnt_rst` is high, all counters are cleared, no pulse is emitted and the input levels are loaded every cycle. Count the first clock edge at which `cnt_rst` is low as edge 1. The first pulse is then visible after edge N.
- R8: While `pwr_dn` is high, the counters and `mod_ctl` hold their values and no pulse is emitted. A period that contains k clock edges of powerdown lasts N + k cycles.
- R9: When `cnt_rst` and `pwr_dn` are both high, the counter reset takes precedence. If both are released at the same edge, the first pulse follows the R7 timing.
- R10: During `rst_n` low, `div_pulse` and `prog_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast divided-oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_val | input | 7 | Swallow count A |
| b_val | input | 11 | Main count B |
| p_sel | input | 1 | Prescaler size: 0 small pair, 1 large pair |
| cnt_rst | input | 1 | Clear and hold the counters |
| pwr_dn | input | 1 | Freeze the counters |
| div_pulse | output | 1 | One-cycle comparison pulse per N cycles |
| mod_ctl | output | 1 | Prescaler modulus control, 1 = P+1 |
| prog_err | output | 1 | Sticky out-of-range programming flag |

## Verification
Counter reset and powerdown can both be active in the same cycle, and they ask for opposite things: one clears the counters, the other freezes them. The bench holds both inputs high together for a stretch and then releases them at the same edge. It checks that no pulse appears during the stretch and that the first pulse arrives exactly N edges after the release, which shows that the clear won. A write that lands at the period boundary is a second such meeting. The bench changes B in the middle of a period and checks that the current period keeps the old length while the next one takes the new length.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int A_W = 7;
  localparam int B_W = 11;
  localparam int B_MIN = 3;

  typedef struct packed {
    logic [A_W-1:0] a;
    logic [B_W-1:0] b;
    logic           plarge;
  } psd_cfg_t;
endpackage

// File: rtl/psd_clamp.sv
module psd_clamp
  import psd_pkg::*;
#(
  parameter int A_MAX = 127
) (
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  input  logic           sel_in,
  output psd_cfg_t       cfg_out,
  output logic           bad
);
  localparam logic [A_W-1:0] A_LIM = A_W'(A_MAX);

  logic [B_W-1:0] b_eff;
  logic [A_W-1:0] a_lim;
  logic [B_W-1:0] a_ext;

  always_comb begin
    b_eff = (b_in < B_W'(B_MIN)) ? B_W'(B_MIN) : b_in;
    a_lim = (a_in > A_LIM) ? A_LIM : a_in;
    a_ext = {{(B_W-A_W){1'b0}}, a_lim};
    cfg_out.b = b_eff;
    cfg_out.a = (a_ext > b_eff) ? b_eff[A_W-1:0] : a_lim;
    cfg_out.plarge = sel_in;
    bad = (b_in < B_W'(B_MIN)) || (a_in > A_LIM) ||
          ({{(B_W-A_W){1'b0}}, a_in} > b_eff);
  end
endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
  parameter int P_SMALL = 64,
  parameter int P_LARGE = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic hold,
  input  logic mod_hi,
  input  logic plarge,
  output logic tick
);
  localparam int PC_W = $clog2(P_LARGE + 1);

  logic [PC_W-1:0] pc;
  logic [PC_W-1:0] term;

  always_comb begin
    term = plarge ? PC_W'(P_LARGE) : PC_W'(P_SMALL);
    if (!mod_hi) term = term - PC_W'(1);
    tick = !clr && !hold && (pc == term);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pc <= '0;
    else if (clr)  pc <= '0;
    else if (hold) pc <= pc;
    else if (tick) pc <= '0;
    else           pc <= pc + PC_W'(1);
  end

  // R8: a frozen prescaler keeps its phase
  p_hold_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(pc));
endmodule

// File: rtl/psd_swallow.sv
module psd_swallow
  import psd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr,
  input  logic     tick,
  input  psd_cfg_t cfg_in,
  output logic     mod_hi,
  output logic     plarge,
  output logic     pulse,
  output logic     reload
);
  psd_cfg_t       act;
  logic [A_W-1:0] a_cnt;
  logic [B_W-1:0] b_cnt;
  logic           last;

  assign last   = tick && (b_cnt == act.b - B_W'(1));
  assign reload = clr || last;
  assign plarge = act.plarge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act    <= '{a: '0, b: B_W'(B_MIN), plarge: 1'b0};
      a_cnt  <= '0;
      b_cnt  <= '0;
      mod_hi <= 1'b0;
      pulse  <= 1'b0;
    end else if (reload) begin
      act    <= cfg_in;
      a_cnt  <= '0;
      b_cnt  <= '0;
      mod_hi <= (cfg_in.a != '0);
      pulse  <= last;
    end else begin
      pulse <= 1'b0;
      if (tick) begin
        b_cnt <= b_cnt + B_W'(1);
        if (mod_hi) begin
          a_cnt <= a_cnt + A_W'(1);
          if (a_cnt + A_W'(1) == act.a) mod_hi <= 1'b0;
        end
      end
    end
  end

  // R1: pulse lasts one cycle
  p_pulse_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
  // R7: no pulse out of a cleared state
  p_clr_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pulse);
  // R2: modulus control only rises at a reload
  p_mod_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_hi) |-> $past(reload));
  // R5: loaded values always lie in the legal range
  p_legal_cfg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ({{(B_W-A_W){1'b0}}, act.a} <= act.b) && (act.b >= B_W'(B_MIN)));
endmodule

// File: rtl/pswallow_divider.sv
module pswallow_divider
  import psd_pkg::*;
#(
  parameter int P_SMALL = 64,
  parameter int P_LARGE = 128,
  parameter int A_MAX   = 127
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [A_W-1:0] a_val,
  input  logic [B_W-1:0] b_val,
  input  logic           p_sel,
  input  logic           cnt_rst,
  input  logic           pwr_dn,
  output logic           div_pulse,
  output logic           mod_ctl,
  output logic           prog_err
);
  psd_cfg_t cfg_c;
  logic     bad_c;
  logic     primed;
  logic     clr;
  logic     hold;
  logic     tick;
  logic     plarge;
  logic     reload;

  assign clr  = cnt_rst || !primed;
  assign hold = pwr_dn && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed   <= 1'b0;
      prog_err <= 1'b0;
    end else begin
      primed   <= 1'b1;
      prog_err <= prog_err || (reload && bad_c);
    end
  end

  psd_clamp #(.A_MAX(A_MAX)) clamp_i (
    .a_in(a_val), .b_in(b_val), .sel_in(p_sel),
    .cfg_out(cfg_c), .bad(bad_c)
  );

  psd_prescaler #(.P_SMALL(P_SMALL), .P_LARGE(P_LARGE)) pre_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .hold(hold),
    .mod_hi(mod_ctl), .plarge(plarge), .tick(tick)
  );

  psd_swallow sw_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .cfg_in(cfg_c),
    .mod_hi(mod_ctl), .plarge(plarge), .pulse(div_pulse), .reload(reload)
  );

  // R6: error flag is sticky
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_err |=> prog_err);
  // R8: powerdown freezes modulus control and blocks pulses
  p_pd_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_dn && !cnt_rst && primed) |=> ($stable(mod_ctl) && !div_pulse));
  // R9: counter reset wins over powerdown
  p_rst_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_rst && pwr_dn) |=> !div_pulse);
endmodule

// File: tb/pswallow_divider_tb_top.sv
module pswallow_divider_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  a_val = '0;
  logic [10:0] b_val = 11'd3;
  logic        p_sel = 1'b0;
  logic        cnt_rst = 1'b0;
  logic        pwr_dn = 1'b0;
  logic        div_pulse, mod_ctl, prog_err;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  pswallow_divider dut_i (
    .clk(clk), .rst_n(rst_n), .a_val(a_val), .b_val(b_val), .p_sel(p_sel),
    .cnt_rst(cnt_rst), .pwr_dn(pwr_dn), .div_pulse(div_pulse),
    .mod_ctl(mod_ctl), .prog_err(prog_err)
  );

  localparam int NV = 6;
  localparam int VA [NV] = '{0, 3, 4, 1, 127, 10};
  localparam int VB [NV] = '{3, 5, 4, 7, 200, 12};
  localparam int VS [NV] = '{0, 0, 1, 1, 0, 0};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_pulse();
    for (int i = 0; i < 30000; i++) begin
      @(negedge clk);
      if (div_pulse) return;
    end
    chk(1'b0, "pulse timeout", 0, 1);
  endtask

  task automatic measure(output int per, output int mh);
    per = 0;
    mh = mod_ctl ? 1 : 0;
    for (int i = 0; i < 30000; i++) begin
      @(negedge clk);
      per++;
      if (div_pulse) return;
      mh += mod_ctl ? 1 : 0;
    end
  endtask

  task automatic release_latency(input string tag, input int exp_n);
    int c;
    int seen;
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (div_pulse) seen++;
    end
    chk(seen == 0, {tag, " no pulse while cleared"}, seen, 0);
    cnt_rst = 1'b0;
    pwr_dn = 1'b0;
    c = 0;
    for (int i = 0; i < 30000; i++) begin
      @(negedge clk);
      c++;
      if (div_pulse) break;
    end
    chk(c == exp_n, {tag, " first pulse latency"}, c, exp_n);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int per, mh, p, n, seen;
    repeat (3) @(negedge clk);
    chk(div_pulse == 1'b0 && prog_err == 1'b0, "R10 reset outputs", {div_pulse, prog_err}, 0);
    rst_n = 1'b1;

    // R1 R2 R3 R4: table walk
    for (int v = 0; v < NV; v++) begin
      a_val = 7'(VA[v]);
      b_val = 11'(VB[v]);
      p_sel = VS[v][0];
      p = VS[v] ? 128 : 64;
      n = p * VB[v] + VA[v];
      wait_pulse();
      measure(per, mh);
      chk(per == n, "R1 R3 period", per, n);
      chk(mh == VA[v] * (p + 1), "R2 modulus-high cycles", mh, VA[v] * (p + 1));
    end
    chk(prog_err == 1'b0, "R5 no error for legal values", prog_err, 0);

    // R7: counter reset latency
    a_val = 7'd3; b_val = 11'd5; p_sel = 1'b0;
    @(negedge clk);
    cnt_rst = 1'b1;
    release_latency("R7", 323);

    // R4: mid-period change keeps current period
    wait_pulse();
    per = 0;
    for (int i = 0; i < 30000; i++) begin
      @(negedge clk);
      per++;
      if (per == 50) b_val = 11'd6;
      if (div_pulse) break;
    end
    chk(per == 323, "R4 current period unchanged", per, 323);
    measure(per, mh);
    chk(per == 387, "R4 next period uses new B", per, 387);

    // R8: powerdown mid-period
    b_val = 11'd5;
    wait_pulse();
    measure(per, mh);
    per = 0;
    seen = 0;
    for (int i = 0; i < 30000; i++) begin
      @(negedge clk);
      per++;
      if (per > 100 && per <= 110 && (mod_ctl != 1'b1 || div_pulse)) seen++;
      if (per == 100) pwr_dn = 1'b1;
      if (per == 110) pwr_dn = 1'b0;
      if (div_pulse && per > 110) break;
    end
    chk(seen == 0, "R8 frozen during powerdown", seen, 0);
    chk(per == 333, "R8 period stretched", per, 333);

    // R9: both together, reset wins
    @(negedge clk);
    cnt_rst = 1'b1;
    pwr_dn = 1'b1;
    release_latency("R9", 323);

    // R5: clamping and error flag
    a_val = 7'd0; b_val = 11'd2;
    wait_pulse();
    chk(prog_err == 1'b1, "R5 error on B below 3", prog_err, 1);
    measure(per, mh);
    chk(per == 192, "R5 B clamped to 3", per, 192);
    a_val = 7'd9; b_val = 11'd5;
    wait_pulse();
    measure(per, mh);
    chk(per == 325, "R5 A clamped to B", per, 325);
    chk(mh == 325, "R5 clamped A modulus-high", mh, 325);

    // R6: sticky until reset
    a_val = 7'd3; b_val = 11'd5;
    wait_pulse();
    measure(per, mh);
    chk(per == 323 && prog_err == 1'b1, "R6 flag stays with legal values", prog_err, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(prog_err == 1'b0 && div_pulse == 1'b0, "R6 R10 cleared by reset", {prog_err, div_pulse}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule